// File: doc/BRIEF.md
# Root Port Error Status Logger

This block sits beside a PCI Express style root port and collects the error reports that reach it. Reports come as strobes from the message receiver, split into a correctable stream and an uncorrectable stream (which also says whether the report was fatal), each carrying a 16-bit requester ID. The port's own detected errors arrive as single-cycle pulses. A self-detected error counts as a message the port sent to itself, with a fixed source ID.

For each category (correctable and uncorrectable) the block holds a first-error flag, a next-error flag and one logged source ID. The first report in a category sets the first flag and records its ID. Reports that arrive while that flag is still set only raise the next flag, and their IDs are dropped. Software reads the flags and IDs through a small register port. It clears flags by writing ones to them, and it picks which kinds of pending error drive the level interrupt output through a three-bit enable register.

Top module: `rpe_logger`

## Requirements
- R1: After reset all status flags, both logged IDs, the enable register and `irq` are zero.
- R2: A correctable report that arrives while the correctable first flag is clear sets that flag (status bit 0) and writes the report's ID into source bits [15:0].
- R3: A non-fatal or fatal report that arrives while the uncorrectable first flag is clear sets that flag (status bit 2) and writes its ID into source bits [31:16]. Status bit 4 (read-only) reads 1 when that first report was fatal.
- R4: A report that arrives while its category's first flag stays set sets that category's next flag (status bit 1 correctable, bit 3 uncorrectable) and leaves the logged ID unchanged.
- R5: A self-detected error is logged like a received report with ID `SELF_ID`. When it coincides with a received report in the same category, the received report's ID is logged and the next flag is also set.
- R6: Writing 1 to status bits 0..3 clears those flags. Writing 0 leaves them unchanged. Clearing the uncorrectable first flag also clears status bit 4.
- R7: Register addresses: 0 is the enable register (bit 0 correctable, bit 1 non-fatal, bit 2 fatal; other bits read zero), 1 is status, 2 holds the source IDs (read-only), and 3 reads zero. Flags and IDs update whatever the enable register holds.
- R8: `irq` is high while a correctable flag is pending with enable bit 0 set, or while uncorrectable flags are pending with a non-fatal report among them and bit 1 set, or with a fatal report among them and bit 2 set.
- R9: If a report arrives in the same cycle in which software clears its category's first flag, the report wins: the first flag stays set, the next flag is not set by it, and the new ID is logged.
- R10: A correctable and an uncorrectable report in the same cycle update both categories independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cor_msg_vld | input | 1 | Correctable report strobe |
| cor_msg_id | input | 16 | Requester ID of the correctable report |
| unc_msg_vld | input | 1 | Uncorrectable report strobe |
| unc_msg_fatal | input | 1 | The uncorrectable report is fatal (else non-fatal) |
| unc_msg_id | input | 16 | Requester ID of the uncorrectable report |
| self_cor_err | input | 1 | Port-detected correctable error pulse |
| self_nonfatal_err | input | 1 | Port-detected non-fatal error pulse |
| self_fatal_err | input | 1 | Port-detected fatal error pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
Every report strobe and every register write takes effect at the rising edge that samples it. The resulting flags, IDs and `irq` can be seen from that edge on, while a read shows the current state in the same cycle. The bench drives strobes and writes on the falling edge, holds them through exactly one rising edge and drops them at the next falling edge. It then sets the read address and samples a moment later, so every check lands one cycle after its stimulus. Same-cycle cases (clear plus report, report in two categories) drive both stimuli on one falling edge so that one rising edge sees them together.

// File: rtl/rpe_pkg.sv
package rpe_pkg;
    localparam int NCAT    = 2;
    localparam int CAT_COR = 0;
    localparam int CAT_UNC = 1;

    typedef enum logic [1:0] {
        RA_ENABLE = 2'd0,
        RA_STATUS = 2'd1,
        RA_SOURCE = 2'd2,
        RA_NONE   = 2'd3
    } reg_addr_e;

    // status field positions
    localparam int ST_COR_FIRST = 0;
    localparam int ST_COR_NEXT  = 1;
    localparam int ST_UNC_FIRST = 2;
    localparam int ST_UNC_NEXT  = 3;
    localparam int ST_UNC_FATAL = 4;

    // enable field positions
    localparam int EN_COR      = 0;
    localparam int EN_NONFATAL = 1;
    localparam int EN_FATAL    = 2;
    localparam int EN_W        = 3;
endpackage

// File: rtl/rpe_category.sv
module rpe_category #(
    parameter int ID_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            msg_vld,
    input  logic [ID_W-1:0] msg_id,
    input  logic            msg_tag,
    input  logic            int_vld,
    input  logic [ID_W-1:0] int_id,
    input  logic            int_tag,
    input  logic            clr_first,
    input  logic            clr_next,
    output logic            first_o,
    output logic            next_o,
    output logic            tag_o,
    output logic [ID_W-1:0] id_o
);
    typedef struct packed {
        logic            first;
        logic            next;
        logic            tag;
        logic [ID_W-1:0] id;
    } cat_state_t;

    cat_state_t st_d, st_q;
    logic held, ev, dual;

    always_comb begin
        held  = st_q.first & ~clr_first;
        ev    = msg_vld | int_vld;
        dual  = msg_vld & int_vld;
        st_d  = st_q;
        st_d.first = held | ev;
        st_d.next  = (st_q.next & ~clr_next) | (ev & held) | dual;
        if (ev && !held) begin
            st_d.id  = msg_vld ? msg_id  : int_id;
            st_d.tag = msg_vld ? msg_tag : int_tag;
        end else if (!held) begin
            st_d.tag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign first_o = st_q.first;
    assign next_o  = st_q.next;
    assign tag_o   = st_q.tag;
    assign id_o    = st_q.id;

    // R2
    first_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && !held) |=> (first_o && id_o == $past(msg_vld ? msg_id : int_id)));
    // R4
    next_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && held) |=> (next_o && $stable(id_o)));
    // R6
    next_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_next && !ev) |=> !next_o);
    // R9
    clear_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_first && msg_vld && !int_vld) |=> (first_o && id_o == $past(msg_id)));
endmodule

// File: rtl/rpe_regs.sv
module rpe_regs
    import rpe_pkg::*;
#(
    parameter int ID_W  = 16,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             cor_first,
    input  logic             cor_next,
    input  logic             unc_first,
    input  logic             unc_next,
    input  logic             unc_fatal,
    input  logic [ID_W-1:0]  cor_id,
    input  logic [ID_W-1:0]  unc_id,
    output logic [EN_W-1:0]  en_o,
    output logic             clr_cor_first,
    output logic             clr_cor_next,
    output logic             clr_unc_first,
    output logic             clr_unc_next,
    output logic [REG_W-1:0] reg_rdata
);
    typedef struct packed {
        logic [EN_W-1:0] en;
    } regs_state_t;

    regs_state_t rs_d, rs_q;
    reg_addr_e   addr;
    logic        wr_status;
    logic        unused_wdata;

    always_comb begin
        addr      = reg_addr_e'(reg_addr);
        rs_d      = rs_q;
        wr_status = reg_wr && (addr == RA_STATUS);
        if (reg_wr && addr == RA_ENABLE) rs_d.en = reg_wdata[EN_W-1:0];
        clr_cor_first = wr_status & reg_wdata[ST_COR_FIRST];
        clr_cor_next  = wr_status & reg_wdata[ST_COR_NEXT];
        clr_unc_first = wr_status & reg_wdata[ST_UNC_FIRST];
        clr_unc_next  = wr_status & reg_wdata[ST_UNC_NEXT];
        reg_rdata = '0;
        case (addr)
            RA_ENABLE: reg_rdata[EN_W-1:0] = rs_q.en;
            RA_STATUS: begin
                reg_rdata[ST_COR_FIRST] = cor_first;
                reg_rdata[ST_COR_NEXT]  = cor_next;
                reg_rdata[ST_UNC_FIRST] = unc_first;
                reg_rdata[ST_UNC_NEXT]  = unc_next;
                reg_rdata[ST_UNC_FATAL] = unc_fatal;
            end
            RA_SOURCE: begin
                reg_rdata[ID_W-1:0]      = cor_id;
                reg_rdata[2*ID_W-1:ID_W] = unc_id;
            end
            default: reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign en_o         = rs_q.en;
    assign unused_wdata = ^reg_wdata[REG_W-1:ST_UNC_FATAL];

    // R7
    en_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == RA_ENABLE) |-> (reg_rdata[REG_W-1:EN_W] == '0));
    // R7
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_ENABLE) |=> (en_o == $past(reg_wdata[EN_W-1:0])));
endmodule

// File: rtl/rpe_irq.sv
module rpe_irq
    import rpe_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EN_W-1:0] en,
    input  logic            cor_pend,
    input  logic            unc_pend,
    input  logic            fatal_ev,
    input  logic            nonfatal_ev,
    output logic            irq
);
    typedef struct packed {
        logic fatal_kind;
        logic nonfatal_kind;
    } kind_state_t;

    kind_state_t ks_d, ks_q;

    always_comb begin
        ks_d.fatal_kind    = (ks_q.fatal_kind    & unc_pend) | fatal_ev;
        ks_d.nonfatal_kind = (ks_q.nonfatal_kind & unc_pend) | nonfatal_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ks_q <= '0;
        else        ks_q <= ks_d;
    end

    assign irq = (en[EN_COR] & cor_pend)
               | (unc_pend & ((en[EN_FATAL] & ks_q.fatal_kind)
                            | (en[EN_NONFATAL] & ks_q.nonfatal_kind)));

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);
    // R8
    irq_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en[EN_FATAL] && fatal_ev) |=> (irq || !$stable(en)));
    // R8
    irq_cor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cor_pend && !unc_pend) |-> !irq);
endmodule

// File: rtl/rpe_logger.sv
module rpe_logger
    import rpe_pkg::*;
#(
    parameter int          ID_W    = 16,
    parameter int          REG_W   = 32,
    parameter logic [15:0] SELF_ID = 16'h0008
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cor_msg_vld,
    input  logic [ID_W-1:0]  cor_msg_id,
    input  logic             unc_msg_vld,
    input  logic             unc_msg_fatal,
    input  logic [ID_W-1:0]  unc_msg_id,
    input  logic             self_cor_err,
    input  logic             self_nonfatal_err,
    input  logic             self_fatal_err,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);
    localparam logic [ID_W-1:0] SELF_ID_W = ID_W'(SELF_ID);

    logic [NCAT-1:0]  c_msg_vld, c_msg_tag, c_int_vld, c_int_tag;
    logic [NCAT-1:0]  c_clr_first, c_clr_next;
    logic [NCAT-1:0]  c_first, c_next, c_tag;
    logic [ID_W-1:0]  c_msg_id [NCAT];
    logic [ID_W-1:0]  c_id     [NCAT];
    logic [EN_W-1:0]  en;
    logic             fatal_ev, nonfatal_ev;

    always_comb begin
        c_msg_vld[CAT_COR] = cor_msg_vld;
        c_msg_tag[CAT_COR] = 1'b0;
        c_msg_id[CAT_COR]  = cor_msg_id;
        c_int_vld[CAT_COR] = self_cor_err;
        c_int_tag[CAT_COR] = 1'b0;
        c_msg_vld[CAT_UNC] = unc_msg_vld;
        c_msg_tag[CAT_UNC] = unc_msg_fatal;
        c_msg_id[CAT_UNC]  = unc_msg_id;
        c_int_vld[CAT_UNC] = self_nonfatal_err | self_fatal_err;
        c_int_tag[CAT_UNC] = self_fatal_err;
        fatal_ev    = (unc_msg_vld & unc_msg_fatal) | self_fatal_err;
        nonfatal_ev = (unc_msg_vld & ~unc_msg_fatal) | self_nonfatal_err;
    end

    for (genvar g = 0; g < NCAT; g++) begin : g_cat
        rpe_category #(.ID_W(ID_W)) u_cat (
            .clk       (clk),
            .rst_n     (rst_n),
            .msg_vld   (c_msg_vld[g]),
            .msg_id    (c_msg_id[g]),
            .msg_tag   (c_msg_tag[g]),
            .int_vld   (c_int_vld[g]),
            .int_id    (SELF_ID_W),
            .int_tag   (c_int_tag[g]),
            .clr_first (c_clr_first[g]),
            .clr_next  (c_clr_next[g]),
            .first_o   (c_first[g]),
            .next_o    (c_next[g]),
            .tag_o     (c_tag[g]),
            .id_o      (c_id[g])
        );
    end

    rpe_regs #(.ID_W(ID_W), .REG_W(REG_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .cor_first     (c_first[CAT_COR]),
        .cor_next      (c_next[CAT_COR]),
        .unc_first     (c_first[CAT_UNC]),
        .unc_next      (c_next[CAT_UNC]),
        .unc_fatal     (c_tag[CAT_UNC]),
        .cor_id        (c_id[CAT_COR]),
        .unc_id        (c_id[CAT_UNC]),
        .en_o          (en),
        .clr_cor_first (c_clr_first[CAT_COR]),
        .clr_cor_next  (c_clr_next[CAT_COR]),
        .clr_unc_first (c_clr_first[CAT_UNC]),
        .clr_unc_next  (c_clr_next[CAT_UNC]),
        .reg_rdata     (reg_rdata)
    );

    rpe_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .cor_pend    (c_first[CAT_COR] | c_next[CAT_COR]),
        .unc_pend    (c_first[CAT_UNC] | c_next[CAT_UNC]),
        .fatal_ev    (fatal_ev),
        .nonfatal_ev (nonfatal_ev),
        .irq         (irq)
    );

    // R10
    both_cat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cor_msg_vld && unc_msg_vld) |=> (c_first[CAT_COR] && c_first[CAT_UNC]));
    // R5
    self_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (self_cor_err && !cor_msg_vld && !c_first[CAT_COR]
         && !c_clr_first[CAT_COR]) |=> (c_id[CAT_COR] == SELF_ID_W));
endmodule

// File: tb/tb_rpe_logger.sv
module tb_rpe_logger;
    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] SELF       = 16'h0008;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cor_msg_vld = 0, unc_msg_vld = 0, unc_msg_fatal = 0;
    logic [15:0] cor_msg_id = 0, unc_msg_id = 0;
    logic        self_cor_err = 0, self_nonfatal_err = 0, self_fatal_err = 0;
    logic        reg_wr = 0;
    logic [1:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rpe_logger #(.SELF_ID(SELF)) dut (
        .clk(clk), .rst_n(rst_n),
        .cor_msg_vld(cor_msg_vld), .cor_msg_id(cor_msg_id),
        .unc_msg_vld(unc_msg_vld), .unc_msg_fatal(unc_msg_fatal), .unc_msg_id(unc_msg_id),
        .self_cor_err(self_cor_err), .self_nonfatal_err(self_nonfatal_err),
        .self_fatal_err(self_fatal_err),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        tick();
        reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic drop_all();
        cor_msg_vld = 0; unc_msg_vld = 0; unc_msg_fatal = 0;
        self_cor_err = 0; self_nonfatal_err = 0; self_fatal_err = 0;
        reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic cor(input logic [15:0] id);
        cor_msg_vld = 1; cor_msg_id = id;
        tick();
        drop_all();
    endtask

    task automatic unc(input logic fatal, input logic [15:0] id);
        unc_msg_vld = 1; unc_msg_fatal = fatal; unc_msg_id = id;
        tick();
        drop_all();
    endtask

    task automatic t_reset();
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd_chk("R1 enable", 2'd0, 32'h0);
        rd_chk("R1 status", 2'd1, 32'h0);
        rd_chk("R1 source", 2'd2, 32'h0);
    endtask

    task automatic t_cor_first_next();
        cor(16'h1234);
        rd_chk("R2 status", 2'd1, 32'h1);
        rd_chk("R2 source", 2'd2, 32'h0000_1234);
        cor(16'hABCD);
        rd_chk("R4 cor next", 2'd1, 32'h3);
        rd_chk("R4 cor id kept", 2'd2, 32'h0000_1234);
        wr(2'd1, 32'h0);
        rd_chk("R6 zero write", 2'd1, 32'h3);
        wr(2'd1, 32'h2);
        rd_chk("R6 clear next", 2'd1, 32'h1);
        wr(2'd1, 32'h1);
        rd_chk("R6 clear first", 2'd1, 32'h0);
    endtask

    task automatic t_unc();
        unc(1'b0, 16'h0101);
        rd_chk("R3 nonfatal status", 2'd1, 32'h4);
        rd_chk("R3 unc id", 2'd2, 32'h0101_1234);
        unc(1'b1, 16'h0202);
        rd_chk("R4 unc next", 2'd1, 32'hC);
        rd_chk("R4 unc id kept", 2'd2, 32'h0101_1234);
        wr(2'd1, 32'hC);
        rd_chk("R6 clear unc", 2'd1, 32'h0);
        unc(1'b1, 16'h0303);
        rd_chk("R3 fatal status", 2'd1, 32'h14);
        rd_chk("R3 fatal id", 2'd2, 32'h0303_1234);
        wr(2'd1, 32'h4);
        rd_chk("R6 fatal tag cleared", 2'd1, 32'h0);
    endtask

    task automatic t_self();
        self_cor_err = 1;
        tick();
        drop_all();
        rd_chk("R5 self cor status", 2'd1, 32'h1);
        rd_chk("R5 self cor id", 2'd2, {16'h0303, SELF});
        wr(2'd1, 32'hF);
        cor_msg_vld = 1; cor_msg_id = 16'h5555; self_cor_err = 1;
        tick();
        drop_all();
        rd_chk("R5 coincident status", 2'd1, 32'h3);
        rd_chk("R5 coincident id", 2'd2, 32'h0303_5555);
        wr(2'd1, 32'hF);
        self_fatal_err = 1;
        tick();
        drop_all();
        rd_chk("R5 self fatal status", 2'd1, 32'h14);
        rd_chk("R5 self fatal id", 2'd2, {SELF, 16'h5555});
        wr(2'd1, 32'hF);
    endtask

    task automatic t_irq();
        wr(2'd0, 32'h7);
        chk("R8 idle irq", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h0);
        cor(16'h0042);
        rd_chk("R7 status with enables off", 2'd1, 32'h1);
        chk("R8 masked irq", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h1);
        chk("R8 cor irq", {31'b0, irq}, 32'h1);
        wr(2'd1, 32'hF);
        chk("R8 cor irq cleared", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h2);
        unc(1'b1, 16'h0777);
        chk("R8 fatal under nonfatal enable", {31'b0, irq}, 32'h0);
        unc(1'b0, 16'h0888);
        chk("R8 nonfatal pending", {31'b0, irq}, 32'h1);
        wr(2'd1, 32'hC);
        chk("R8 unc cleared", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h4);
        unc(1'b1, 16'h0999);
        chk("R8 fatal irq", {31'b0, irq}, 32'h1);
        wr(2'd1, 32'hF);
        chk("R8 fatal cleared", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'hFFFF_FFFF);
        rd_chk("R7 enable readback", 2'd0, 32'h7);
        rd_chk("R7 addr3 zero", 2'd3, 32'h0);
        wr(2'd2, 32'hFFFF_FFFF);
        rd_chk("R7 source read-only", 2'd2, 32'h0999_0042);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_clear_race();
        cor(16'h1111);
        reg_addr = 2'd1; reg_wdata = 32'h1; reg_wr = 1;
        cor_msg_vld = 1; cor_msg_id = 16'h2222;
        tick();
        drop_all();
        rd_chk("R9 status", 2'd1, 32'h1);
        rd_chk("R9 new id", 2'd2, 32'h0999_2222);
        wr(2'd1, 32'hF);
    endtask

    task automatic t_both();
        cor_msg_vld = 1; cor_msg_id = 16'h0A0A;
        unc_msg_vld = 1; unc_msg_fatal = 0; unc_msg_id = 16'h0B0B;
        tick();
        drop_all();
        rd_chk("R10 status", 2'd1, 32'h5);
        rd_chk("R10 ids", 2'd2, 32'h0B0B_0A0A);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cor_first_next();
        t_unc();
        t_self();
        t_irq();
        t_clear_race();
        t_both();
        done = 1;
        summary();
        $finish;
    end
endmodule